// File: doc/BRIEF.md
# Core Operating-Point Transition Sequencer

This block moves a processor core between its normal (high) operating point and a reduced (low) operating point when the power-state controller asks it to enter or leave the enhanced idle state. It keeps the present core clock ratio and the present voltage identification code in registers. When an entry sequence starts, it also copies both values into save registers. Each change is handed to the clock generator or to the voltage regulator as a request with a target value. The request stays raised until that agent returns a done strobe. The done strobe stands in for PLL relock and for regulator settling.

The order of the steps differs by direction. Going down, the ratio is lowered first and the voltage code second. Coming back, the voltage code is restored first and the ratio second, so the core never runs a high ratio on a low voltage. The bus clock selection is a separate output and no sequence touches it. When the feature is disabled, an entry request is acknowledged at once and nothing changes. A break event that arrives while an entry is in progress is held until the current step ends. The block then unwinds from the point it has reached.

Top module: `opp_seq`

## Requirements
- R1: In the cycle after reset is sampled high, cur_ratio equals HI_RATIO, cur_vid equals HI_VID, and ratio_req, vid_req, seq_done and in_low are all 0.
- R2: With feat_en=1, an enter_req pulse in the high state raises ratio_req with ratio_tgt=LO_RATIO on the next cycle. ratio_req then stays high until a cycle in which ratio_done is 1.
- R3: During entry, vid_req (vid_tgt=LO_VID) rises only after the ratio step has been acknowledged and cur_ratio already equals LO_RATIO. When vid_done arrives, cur_vid becomes LO_VID and in_low becomes 1.
- R4: An exit_req in the low state first raises vid_req with vid_tgt set to the saved voltage code. The ratio restore request (ratio_tgt set to the saved ratio) rises only after vid_done, while cur_vid is no longer LO_VID.
- R5: seq_done is a one-cycle pulse. It appears in the cycle after the final acknowledge of a complete entry or a complete exit, and after an entry request with the feature disabled.
- R6: bus_ratio holds BUS_CODE at all times and no sequence alters it.
- R7: With feat_en=0, enter_req gives a seq_done pulse on the next cycle. No request is raised, and cur_ratio and cur_vid keep their values.
- R8: At the start of each entry the save registers capture cur_ratio and cur_vid. The exit targets are these captured values.
- R9: An exit_req during the ratio-lowering step takes effect only when ratio_done arrives. The block then restores the saved ratio directly and the voltage code is never lowered.
- R10: An exit_req during the voltage-lowering step takes effect only when vid_done arrives. The voltage is then restored before the ratio, and seq_done does not pulse until the ratio restore completes.
- R11: ratio_done and vid_done have no effect while the matching request is low. cur_ratio and cur_vid change only in a cycle that follows an acknowledged request.
- R12: ratio_req and vid_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Enables operating-point changes on entry |
| enter_req | input | 1 | One-cycle request to enter the low-power state |
| exit_req | input | 1 | One-cycle break event requesting exit |
| ratio_done | input | 1 | Clock generator has settled on ratio_tgt |
| vid_done | input | 1 | Regulator has settled on vid_tgt |
| ratio_req | output | 1 | Ratio change request, held until ratio_done |
| ratio_tgt | output | RW | Requested core ratio |
| vid_req | output | 1 | Voltage change request, held until vid_done |
| vid_tgt | output | VW | Requested voltage identification code |
| cur_ratio | output | RW | Current core ratio |
| cur_vid | output | VW | Current voltage identification code |
| bus_ratio | output | BW | Bus clock selection, fixed |
| in_low | output | 1 | Core sits at the low operating point |
| seq_done | output | 1 | One-cycle completion pulse to the controller |

## Verification
The assertions take for granted that the controller never raises enter_req and exit_req in the same cycle. They also assume it never repeats a disabled-mode enter_req in back-to-back cycles, since that would make seq_done look wider than one cycle. The stimulus follows these rules: it drives each request as a single-cycle pulse with idle cycles between pulses. The done strobes come from a responder that waits two to four cycles after seeing a request. Stray done strobes are injected only while no request is raised.

// File: rtl/opp_pkg.sv
package opp_pkg;

    typedef enum logic [2:0] {
        ST_HIGH,
        ST_ENT_RATIO,
        ST_ENT_VID,
        ST_LOW,
        ST_EXT_VID,
        ST_EXT_RATIO
    } opp_state_e;

    // Per-cycle step command from the controller to the value registers
    typedef struct packed {
        logic ratio_go;
        logic vid_go;
        logic to_low;
        logic save;
    } step_t;

    function automatic logic is_entry(opp_state_e s);
        return (s == ST_ENT_RATIO) || (s == ST_ENT_VID);
    endfunction

endpackage

// File: rtl/opp_step_ctrl.sv
module opp_step_ctrl
    import opp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       feat_en,
    input  logic       enter_req,
    input  logic       exit_req,
    input  logic       ratio_done,
    input  logic       vid_done,
    output step_t      step,
    output opp_state_e state,
    output logic       seq_done
);

    opp_state_e state_q, state_d;
    logic       pend_q;
    logic       exit_any;
    logic       finish;

    assign exit_any = pend_q | exit_req;

    always_comb begin
        state_d     = state_q;
        finish      = 1'b0;
        step.save   = 1'b0;
        step.ratio_go = (state_q == ST_ENT_RATIO) || (state_q == ST_EXT_RATIO);
        step.vid_go   = (state_q == ST_ENT_VID)   || (state_q == ST_EXT_VID);
        step.to_low   = is_entry(state_q);
        case (state_q)
            ST_HIGH: begin
                if (enter_req) begin
                    if (feat_en) begin
                        state_d   = ST_ENT_RATIO;
                        step.save = 1'b1;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_ENT_RATIO: begin
                if (ratio_done) state_d = exit_any ? ST_EXT_RATIO : ST_ENT_VID;
            end
            ST_ENT_VID: begin
                if (vid_done) begin
                    state_d = exit_any ? ST_EXT_VID : ST_LOW;
                    finish  = ~exit_any;
                end
            end
            ST_LOW: begin
                if (exit_req) state_d = ST_EXT_VID;
            end
            ST_EXT_VID: begin
                if (vid_done) state_d = ST_EXT_RATIO;
            end
            ST_EXT_RATIO: begin
                if (ratio_done) begin
                    state_d = ST_HIGH;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HIGH;
            pend_q   <= 1'b0;
            seq_done <= 1'b0;
        end else begin
            state_q  <= state_d;
            pend_q   <= is_entry(state_d) ? exit_any : 1'b0;
            seq_done <= finish;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/opp_field.sv
module opp_field #(
    parameter int           W  = 8,
    parameter logic [W-1:0] HI = '1,
    parameter logic [W-1:0] LO = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         done,
    input  logic         to_low,
    input  logic         save,
    output logic [W-1:0] tgt,
    output logic [W-1:0] cur
);

    logic [W-1:0] cur_q;
    logic [W-1:0] sav_q;

    assign tgt = to_low ? LO : sav_q;
    assign cur = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= HI;
            sav_q <= HI;
        end else begin
            if (save)       sav_q <= cur_q;
            if (go && done) cur_q <= tgt;
        end
    end

endmodule

// File: rtl/opp_seq.sv
module opp_seq
    import opp_pkg::*;
#(
    parameter int            RW        = 6,
    parameter int            VW        = 8,
    parameter int            BW        = 3,
    parameter logic [RW-1:0] HI_RATIO  = 6'd18,
    parameter logic [RW-1:0] LO_RATIO  = 6'd6,
    parameter logic [VW-1:0] HI_VID    = 8'h3C,
    parameter logic [VW-1:0] LO_VID    = 8'h20,
    parameter logic [BW-1:0] BUS_CODE  = 3'd4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          feat_en,
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          ratio_done,
    input  logic          vid_done,
    output logic          ratio_req,
    output logic [RW-1:0] ratio_tgt,
    output logic          vid_req,
    output logic [VW-1:0] vid_tgt,
    output logic [RW-1:0] cur_ratio,
    output logic [VW-1:0] cur_vid,
    output logic [BW-1:0] bus_ratio,
    output logic          in_low,
    output logic          seq_done
);

    step_t      step;
    opp_state_e state;
    logic [BW-1:0] bus_q;

    opp_step_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .feat_en    (feat_en),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .ratio_done (ratio_done),
        .vid_done   (vid_done),
        .step       (step),
        .state      (state),
        .seq_done   (seq_done)
    );

    opp_field #(.W(RW), .HI(HI_RATIO), .LO(LO_RATIO)) u_ratio (
        .clk    (clk),
        .rst    (rst),
        .go     (step.ratio_go),
        .done   (ratio_done),
        .to_low (step.to_low),
        .save   (step.save),
        .tgt    (ratio_tgt),
        .cur    (cur_ratio)
    );

    opp_field #(.W(VW), .HI(HI_VID), .LO(LO_VID)) u_vid (
        .clk    (clk),
        .rst    (rst),
        .go     (step.vid_go),
        .done   (vid_done),
        .to_low (step.to_low),
        .save   (step.save),
        .tgt    (vid_tgt),
        .cur    (cur_vid)
    );

    // Bus clock selection: loaded at reset, never written by a sequence
    always_ff @(posedge clk) begin
        if (rst) bus_q <= BUS_CODE;
    end

    assign bus_ratio = bus_q;
    assign ratio_req = step.ratio_go;
    assign vid_req   = step.vid_go;
    assign in_low    = (state == ST_LOW);

endmodule

// File: rtl/opp_seq_chk.sv
module opp_seq_chk #(
    parameter int            RW       = 6,
    parameter int            VW       = 8,
    parameter logic [RW-1:0] LO_RATIO = 6'd6,
    parameter logic [VW-1:0] LO_VID   = 8'h20
) (
    input logic          clk,
    input logic          rst,
    input logic          ratio_done,
    input logic          vid_done,
    input logic          ratio_req,
    input logic [RW-1:0] ratio_tgt,
    input logic          vid_req,
    input logic [VW-1:0] vid_tgt,
    input logic [RW-1:0] cur_ratio,
    input logic [VW-1:0] cur_vid,
    input logic          seq_done
);

    p_one_step_r12: assert property (@(posedge clk) disable iff (rst)
        !(ratio_req && vid_req));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ratio_req && !ratio_done) |=> ratio_req);

    p_vid_low_after_ratio_r3: assert property (@(posedge clk) disable iff (rst)
        (vid_req && vid_tgt == LO_VID) |-> cur_ratio == LO_RATIO);

    p_ratio_up_after_vid_r4: assert property (@(posedge clk) disable iff (rst)
        (ratio_req && ratio_tgt != LO_RATIO) |-> cur_vid != LO_VID);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    p_vid_moves_on_ack_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_vid) |-> $past(vid_req && vid_done));

    p_ratio_moves_on_ack_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_ratio) |-> $past(ratio_req && ratio_done));

endmodule

bind opp_seq opp_seq_chk #(
    .RW(RW), .VW(VW), .LO_RATIO(LO_RATIO), .LO_VID(LO_VID)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ratio_done (ratio_done),
    .vid_done   (vid_done),
    .ratio_req  (ratio_req),
    .ratio_tgt  (ratio_tgt),
    .vid_req    (vid_req),
    .vid_tgt    (vid_tgt),
    .cur_ratio  (cur_ratio),
    .cur_vid    (cur_vid),
    .seq_done   (seq_done)
);

// File: tb/opp_seq_tb.sv
module opp_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HI_R = 18;
    localparam int LO_R = 6;
    localparam int HI_V = 'h3C;
    localparam int LO_V = 'h20;
    localparam int BUS  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       feat_en = 1'b0;
    logic       enter_req = 1'b0;
    logic       exit_req = 1'b0;
    logic       resp_r = 1'b0, kick_r = 1'b0;
    logic       resp_v = 1'b0, kick_v = 1'b0;
    logic       ratio_done, vid_done;
    logic       ratio_req, vid_req, in_low, seq_done;
    logic [5:0] ratio_tgt, cur_ratio;
    logic [7:0] vid_tgt, cur_vid;
    logic [2:0] bus_ratio;

    assign ratio_done = resp_r | kick_r;
    assign vid_done   = resp_v | kick_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    opp_seq u_dut (
        .clk(clk), .rst(rst), .feat_en(feat_en), .enter_req(enter_req),
        .exit_req(exit_req), .ratio_done(ratio_done), .vid_done(vid_done),
        .ratio_req(ratio_req), .ratio_tgt(ratio_tgt), .vid_req(vid_req),
        .vid_tgt(vid_tgt), .cur_ratio(cur_ratio), .cur_vid(cur_vid),
        .bus_ratio(bus_ratio), .in_low(in_low), .seq_done(seq_done)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R1";
    bit    finished = 0;

    // Behavioural reference: phase 0 idle-high, 1 lowering ratio, 2 lowering
    // voltage, 3 low, 4 raising voltage, 5 raising ratio
    int m_st = 0, m_ratio = HI_R, m_vid = HI_V, s_ratio = HI_R, s_vid = HI_V;
    bit m_pend = 0, m_done = 0, m_ex = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ratio = HI_R; m_vid = HI_V; s_ratio = HI_R; s_vid = HI_V;
            m_pend = 0; m_done = 0;
        end else begin
            m_ex = m_pend || exit_req;
            m_done = 0;
            case (m_st)
                0: if (enter_req) begin
                       if (feat_en) begin s_ratio = m_ratio; s_vid = m_vid; m_st = 1; end
                       else m_done = 1;
                   end
                1: if (ratio_done) begin m_ratio = LO_R; m_st = m_ex ? 5 : 2; end
                2: if (vid_done) begin
                       m_vid = LO_V;
                       if (m_ex) m_st = 4; else begin m_st = 3; m_done = 1; end
                   end
                3: if (exit_req) m_st = 4;
                4: if (vid_done) begin m_vid = s_vid; m_st = 5; end
                5: if (ratio_done) begin m_ratio = s_ratio; m_st = 0; m_done = 1; end
                default: m_st = 0;
            endcase
            m_pend = (m_st == 1 || m_st == 2) ? m_ex : 0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare against the reference away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!finished) begin
            check(tag, "cur_ratio", int'(cur_ratio), m_ratio);
            check(tag, "cur_vid", int'(cur_vid), m_vid);
            check(tag, "ratio_req", int'(ratio_req), int'(m_st == 1 || m_st == 5));
            check(tag, "vid_req", int'(vid_req), int'(m_st == 2 || m_st == 4));
            if (m_st == 1) check(tag, "ratio_tgt", int'(ratio_tgt), LO_R);
            if (m_st == 5) check(tag, "ratio_tgt", int'(ratio_tgt), s_ratio);
            if (m_st == 2) check(tag, "vid_tgt", int'(vid_tgt), LO_V);
            if (m_st == 4) check(tag, "vid_tgt", int'(vid_tgt), s_vid);
            check(tag, "seq_done", int'(seq_done), int'(m_done));
            check(tag, "in_low", int'(in_low), int'(m_st == 3));
            check("R6", "bus_ratio", int'(bus_ratio), BUS);
            check("R12", "both requests", int'(ratio_req && vid_req), 0);
        end
    end

    // Done responder: acknowledges a raised request after 2..4 cycles
    int rcnt = 0, vcnt = 0, nresp = 0;
    always @(negedge clk) begin
        if (resp_r) resp_r = 1'b0;
        else if (ratio_req) begin
            rcnt++;
            if (rcnt >= 2 + nresp % 3) begin resp_r = 1'b1; rcnt = 0; nresp++; end
        end else rcnt = 0;
        if (resp_v) resp_v = 1'b0;
        else if (vid_req) begin
            vcnt++;
            if (vcnt >= 2 + nresp % 3) begin resp_v = 1'b1; vcnt = 0; nresp++; end
        end else vcnt = 0;
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_enter();
        enter_req = 1'b1; @(negedge clk); enter_req = 1'b0;
    endtask

    task automatic pulse_exit();
        exit_req = 1'b1; @(negedge clk); exit_req = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        // R7: feature disabled, entry acknowledged with no change
        tag = "R7";
        pulse_enter();
        idle(4);
        check("R7", "ratio kept", int'(cur_ratio), HI_R);

        // R11: stray acknowledges while nothing is requested
        tag = "R11";
        kick_r = 1'b1; kick_v = 1'b1; @(negedge clk); kick_r = 1'b0; kick_v = 1'b0;
        idle(3);
        check("R11", "ratio untouched", int'(cur_ratio), HI_R);
        check("R11", "vid untouched", int'(cur_vid), HI_V);

        // R2 / R3: full entry
        feat_en = 1'b1;
        tag = "R2";
        pulse_enter();
        tag = "R3";
        idle(20);
        check("R3", "in_low after entry", int'(in_low), 1);

        // R11 again: stray acknowledges while parked low
        tag = "R11";
        kick_r = 1'b1; kick_v = 1'b1; @(negedge clk); kick_r = 1'b0; kick_v = 1'b0;
        idle(2);
        check("R11", "low vid held", int'(cur_vid), LO_V);

        // R4 / R5 / R8: full exit back to captured values
        tag = "R4";
        pulse_exit();
        tag = "R5";
        idle(20);
        check("R8", "ratio restored", int'(cur_ratio), HI_R);
        check("R8", "vid restored", int'(cur_vid), HI_V);

        // R9: break during the ratio-lowering step
        tag = "R9";
        pulse_enter();
        pulse_exit();
        idle(20);
        check("R9", "vid never lowered", int'(cur_vid), HI_V);

        // R10: break during the voltage-lowering step
        tag = "R10";
        pulse_enter();
        for (int i = 0; i < 30 && !vid_req; i++) @(negedge clk);
        pulse_exit();
        idle(25);
        check("R10", "back high", int'(cur_ratio), HI_R);

        // R8: a second full cycle reuses freshly captured values
        tag = "R8";
        pulse_enter();
        idle(20);
        pulse_exit();
        idle(20);
        summary();
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule